// File: doc/BRIEF.md
# Frame-Slot Micro-Program Sequencer

This block is the control sequencer of a slot-based audio synthesis and signal-processing engine. It divides each audio frame into a fixed number of process slots and visits them in ascending order. In each slot it steps through a fixed-length micro-program, issuing one micro-instruction per clock with no idle cycles between slots. Each slot picks its micro-program from a shared algorithm store through a per-slot selection table. A per-slot link table lets a slot pass its working context on to the following slot, so several consecutive slots can act as one longer algorithm.

A host port writes the algorithm store, the selection table and the link table while the sequence runs, and is never stalled. For every issued instruction the block presents the fetched 32-bit word together with the slot and step it belongs to, a context-keep flag that tells the datapath not to clear its accumulators, and a frame-start marker. A run input halts the sequence in place. While halted the block issues a no-operation word of all zeros.

Top module: `slot_seq_top`

## Requirements
- R1: While `run` is high, the step advances by one on every clock from 0 to STEPS-1. After the last step the slot advances by one. After the last step of slot SLOTS-1 the position wraps to slot 0, step 0. Each issued instruction appears on the outputs one cycle after issue, with `out_slot` and `out_step` naming its position.
- R2: The word issued for step s of a slot that uses algorithm a is the algorithm store entry at address a*STEPS+s, that is {a, s}. It appears on `out_word` one clock after issue, and `out_valid` is high in that cycle.
- R3: The selection table entry of a slot is read at step 0 and used for every step of that slot. A host write to that entry made during the slot takes effect from the slot's next visit.
- R4: `out_keep` is high for every instruction of slot N+1 when the link entry of slot N was set at step 0 of slot N+1. It is never high for slot 0, even when the link entry of the last slot is set.
- R5: `out_frame_start` is high exactly in the output cycle of the instruction issued for slot 0, step 0.
- R6: While `run` is low the slot and step do not change. One cycle later `out_valid`, `out_keep` and `out_frame_start` are low and `out_word` is zero. When `run` returns high the sequence resumes at the position where it stopped.
- R7: A synchronous `rst` returns the position to slot 0, step 0, clears every output to zero, and clears all selection entries to algorithm 0 and all link entries to 0. It leaves the algorithm store unchanged.
- R8: A host write is accepted in any cycle when `host_we` is high. It does not stop or delay the sequence. `host_tgt` selects the target: 0 writes the algorithm store at `host_addr` with `host_wdata`; 1 writes the selection entry of slot `host_addr` with the low bits of `host_wdata` that hold an algorithm number; 2 writes the link entry of slot `host_addr` with `host_wdata[0]`; 3 changes nothing.
- R9: When a host write to the algorithm store hits the address being fetched in the same cycle, the fetched word is the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction per cycle |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | High to issue instructions, low to halt in place |
| host_we | input | 1 | Host write strobe |
| host_tgt | input | 2 | Host write target: 0 store, 1 selection, 2 link, 3 none |
| host_addr | input | HADDR_W | Store address {algorithm, step}, or slot number for the tables |
| host_wdata | input | WORD_W | Host write data |
| out_valid | output | 1 | An issued instruction is on the outputs |
| out_frame_start | output | 1 | The instruction is slot 0, step 0 |
| out_keep | output | 1 | The datapath keeps its context for this slot |
| out_slot | output | SLOT_W | Slot of the instruction on the outputs |
| out_step | output | STEP_W | Step of the instruction on the outputs |
| out_word | output | WORD_W | Fetched micro-instruction, zero when not valid |

## Verification
The bench builds the block with 8 slots, 4 steps per slot, 4 algorithms and 32-bit words, so a frame lasts only 32 cycles. This small geometry lets a short run cover many frame wraps, link chains that end on the last slot, and halts at every slot and step position. With only 16 store addresses, host writes made on every cycle often hit the address being fetched in that same cycle, and mid-slot writes to the selection entry of the running slot occur many times. A behavioural model drives expectations for every output on every clock.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

    // Host write target encoding
    typedef enum logic [1:0] {
        HT_STORE  = 2'd0,
        HT_SELECT = 2'd1,
        HT_LINK   = 2'd2,
        HT_NONE   = 2'd3
    } host_tgt_e;

endpackage

// File: rtl/seq_position.sv
module seq_position #(
    parameter int SLOTS = 64,
    parameter int STEPS = 16,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [SLOT_W-1:0] slot_q,
    output logic [STEP_W-1:0] step_q
);

    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [STEP_W-1:0] step;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (run) begin
            if (pos_q.step == STEP_LAST) begin
                pos_d.step = '0;
                pos_d.slot = (pos_q.slot == SLOT_LAST) ? '0 : pos_q.slot + 1'b1;
            end else begin
                pos_d.step = pos_q.step + 1'b1;
            end
        end
        if (rst) begin
            pos_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        pos_q <= pos_d;
    end

    assign slot_q = pos_q.slot;
    assign step_q = pos_q.step;

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (run && step_q != STEP_LAST) |=> (step_q == STEP_W'($past(step_q) + 1'b1))); // R1

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && step_q == STEP_LAST && slot_q == SLOT_LAST) |=> (slot_q == '0 && step_q == '0)); // R1

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(slot_q) && $stable(step_q))); // R6

endmodule

// File: rtl/slot_tables.sv
module slot_tables #(
    parameter int SLOTS = 64,
    parameter int ALGS  = 32,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ALG_W  = $clog2(ALGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  logic              link_we,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [ALG_W-1:0]  wr_alg,
    input  logic              wr_link,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [ALG_W-1:0]  rd_alg,
    output logic              rd_prev_link
);

    logic [ALG_W-1:0] sel_d [SLOTS];
    logic [ALG_W-1:0] sel_q [SLOTS];
    logic [SLOTS-1:0] link_d, link_q;
    logic             wr_in_range;
    logic [SLOT_W-1:0] prev_slot;

    assign wr_in_range = int'(wr_slot) < SLOTS;

    always_comb begin
        sel_d  = sel_q;
        link_d = link_q;
        if (sel_we && wr_in_range) begin
            sel_d[wr_slot] = wr_alg;
        end
        if (link_we && wr_in_range) begin
            link_d[wr_slot] = wr_link;
        end
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                sel_d[i] = '0;
            end
            link_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        sel_q  <= sel_d;
        link_q <= link_d;
    end

    // Reads see the registered contents: a write lands one cycle later.
    assign prev_slot    = rd_slot - 1'b1;
    assign rd_alg       = sel_q[rd_slot];
    assign rd_prev_link = (rd_slot != '0) && link_q[prev_slot];

    AST_TABLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (sel_we && wr_in_range) |=> (sel_q[$past(wr_slot)] == $past(wr_alg))); // R8

endmodule

// File: rtl/alg_store.sv
module alg_store #(
    parameter int WORDS  = 512,
    parameter int WORD_W = 32,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [WORDS];

    // Single write port, single registered read port; read returns old data
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/slot_seq_top.sv
module slot_seq_top #(
    parameter int SLOTS  = 64,
    parameter int STEPS  = 16,
    parameter int ALGS   = 32,
    parameter int WORD_W = 32,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int STEP_W  = $clog2(STEPS),
    localparam int ALG_W   = $clog2(ALGS),
    localparam int IADDR_W = ALG_W + STEP_W,
    localparam int HADDR_W = (IADDR_W > SLOT_W) ? IADDR_W : SLOT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               host_we,
    input  logic [1:0]         host_tgt,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic               out_valid,
    output logic               out_frame_start,
    output logic               out_keep,
    output logic [SLOT_W-1:0]  out_slot,
    output logic [STEP_W-1:0]  out_step,
    output logic [WORD_W-1:0]  out_word
);

    import slot_seq_pkg::*;

    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

    typedef struct packed {
        logic [ALG_W-1:0] alg;
        logic             keep;
    } hold_t;

    typedef struct packed {
        logic              valid;
        logic              fs;
        logic              keep;
        logic [SLOT_W-1:0] slot;
        logic [STEP_W-1:0] step;
    } outs_t;

    logic [SLOT_W-1:0]  slot_q;
    logic [STEP_W-1:0]  step_q;
    logic [ALG_W-1:0]   tab_alg;
    logic               tab_prev_link;
    logic [IADDR_W-1:0] fetch_addr;
    logic [WORD_W-1:0]  fetch_word;
    logic               store_we, sel_we, link_we;
    logic               at_step0;
    logic [ALG_W-1:0]   alg_now;
    logic               keep_now;
    hold_t              hold_d, hold_q;
    outs_t              outs_d, outs_q;
    logic               unused_host_bits;

    // Host write decode: every write is accepted, the sequence never waits
    assign store_we = host_we && (host_tgt_e'(host_tgt) == HT_STORE);
    assign sel_we   = host_we && (host_tgt_e'(host_tgt) == HT_SELECT);
    assign link_we  = host_we && (host_tgt_e'(host_tgt) == HT_LINK);
    assign unused_host_bits = ^{host_addr, host_wdata};

    seq_position #(
        .SLOTS (SLOTS),
        .STEPS (STEPS)
    ) u_position (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .slot_q (slot_q),
        .step_q (step_q)
    );

    slot_tables #(
        .SLOTS (SLOTS),
        .ALGS  (ALGS)
    ) u_tables (
        .clk          (clk),
        .rst          (rst),
        .sel_we       (sel_we),
        .link_we      (link_we),
        .wr_slot      (host_addr[SLOT_W-1:0]),
        .wr_alg       (host_wdata[ALG_W-1:0]),
        .wr_link      (host_wdata[0]),
        .rd_slot      (slot_q),
        .rd_alg       (tab_alg),
        .rd_prev_link (tab_prev_link)
    );

    alg_store #(
        .WORDS  (ALGS * STEPS),
        .WORD_W (WORD_W)
    ) u_store (
        .clk   (clk),
        .we    (store_we),
        .waddr (host_addr[IADDR_W-1:0]),
        .wdata (host_wdata),
        .raddr (fetch_addr),
        .rdata (fetch_word)
    );

    always_comb begin
        at_step0 = (step_q == '0);
        alg_now  = at_step0 ? tab_alg       : hold_q.alg;
        keep_now = at_step0 ? tab_prev_link : hold_q.keep;

        hold_d = hold_q;
        if (run && at_step0) begin
            hold_d.alg  = tab_alg;
            hold_d.keep = tab_prev_link;
        end

        outs_d.valid = run;
        outs_d.fs    = run && at_step0 && (slot_q == '0);
        outs_d.keep  = run && keep_now;
        outs_d.slot  = slot_q;
        outs_d.step  = step_q;

        if (rst) begin
            hold_d = '0;
            outs_d = '0;
        end
    end

    assign fetch_addr = {alg_now, step_q};

    always_ff @(posedge clk) begin
        hold_q <= hold_d;
        outs_q <= outs_d;
    end

    assign out_valid       = outs_q.valid;
    assign out_frame_start = outs_q.fs;
    assign out_keep        = outs_q.keep;
    assign out_slot        = outs_q.slot;
    assign out_step        = outs_q.step;
    assign out_word        = outs_q.valid ? fetch_word : '0;

    AST_OUT_STEP_SEQ: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_step != STEP_LAST) |=> (out_step == STEP_W'($past(out_step) + 1'b1))); // R1

    AST_ALG_HELD: assert property (@(posedge clk) disable iff (rst)
        !(run && step_q == '0) |=> $stable(hold_q)); // R3

    AST_KEEP_NOT_SLOT0: assert property (@(posedge clk) disable iff (rst)
        out_keep |-> (out_slot != '0 && out_valid)); // R4

    AST_FRAME_START_POS: assert property (@(posedge clk) disable iff (rst)
        out_frame_start |-> (out_valid && out_slot == '0 && out_step == '0)); // R5

    AST_HALT_NOP: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!out_valid && !out_keep && !out_frame_start && out_word == '0)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_slot == '0 && out_step == '0 && slot_q == '0 && step_q == '0)); // R7

endmodule

// File: tb/test_slot_seq_top.sv
module test_slot_seq_top;

    localparam int SLOTS  = 8;
    localparam int STEPS  = 4;
    localparam int ALGS   = 4;
    localparam int WORD_W = 32;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int STEP_W = $clog2(STEPS);
    localparam int ALG_W  = $clog2(ALGS);
    localparam int IADDR_W = ALG_W + STEP_W;
    localparam int HADDR_W = (IADDR_W > SLOT_W) ? IADDR_W : SLOT_W;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               run = 1'b0;
    logic               host_we = 1'b0;
    logic [1:0]         host_tgt = 2'd0;
    logic [HADDR_W-1:0] host_addr = '0;
    logic [WORD_W-1:0]  host_wdata = '0;
    logic               out_valid, out_frame_start, out_keep;
    logic [SLOT_W-1:0]  out_slot;
    logic [STEP_W-1:0]  out_step;
    logic [WORD_W-1:0]  out_word;

    int    checks = 0;
    int    errors = 0;
    bit    model_ready = 1'b0;
    bit    done = 1'b0;
    string phase = "R7 reset";

    // Behavioural model state
    int m_slot, m_step, m_alg, m_keep;
    int sel_m [SLOTS];
    int lnk_m [SLOTS];
    int mem_m [ALGS*STEPS];
    int e_valid, e_fs, e_keep, e_slot, e_step;
    logic [WORD_W-1:0] e_word;

    slot_seq_top #(
        .SLOTS  (SLOTS),
        .STEPS  (STEPS),
        .ALGS   (ALGS),
        .WORD_W (WORD_W)
    ) i_slot_seq_top (
        .clk             (clk),
        .rst             (rst),
        .run             (run),
        .host_we         (host_we),
        .host_tgt        (host_tgt),
        .host_addr       (host_addr),
        .host_wdata      (host_wdata),
        .out_valid       (out_valid),
        .out_frame_start (out_frame_start),
        .out_keep        (out_keep),
        .out_slot        (out_slot),
        .out_step        (out_step),
        .out_word        (out_word)
    );

    always #10 clk = ~clk;

    // Reference model: expectations for the outputs after this edge
    always @(posedge clk) begin
        int a, k;
        if (rst) begin
            m_slot = 0; m_step = 0; m_alg = 0; m_keep = 0;
            for (int i = 0; i < SLOTS; i++) begin
                sel_m[i] = 0;
                lnk_m[i] = 0;
            end
            e_valid = 0; e_fs = 0; e_keep = 0; e_slot = 0; e_step = 0; e_word = '0;
        end else begin
            e_slot = m_slot;
            e_step = m_step;
            if (run) begin
                a = (m_step == 0) ? sel_m[m_slot] : m_alg;
                k = (m_step == 0) ? ((m_slot != 0) ? lnk_m[m_slot-1] : 0) : m_keep;
                m_alg = a;
                m_keep = k;
                e_valid = 1;
                e_fs = (m_slot == 0 && m_step == 0) ? 1 : 0;
                e_keep = k;
                e_word = mem_m[a*STEPS + m_step];
                m_step = m_step + 1;
                if (m_step == STEPS) begin
                    m_step = 0;
                    m_slot = (m_slot + 1) % SLOTS;
                end
            end else begin
                e_valid = 0; e_fs = 0; e_keep = 0; e_word = '0;
            end
            if (host_we && host_tgt == 2'd1) sel_m[host_addr[SLOT_W-1:0]] = int'(host_wdata[ALG_W-1:0]);
            if (host_we && host_tgt == 2'd2) lnk_m[host_addr[SLOT_W-1:0]] = int'(host_wdata[0]);
        end
        if (host_we && host_tgt == 2'd0) mem_m[host_addr[IADDR_W-1:0]] = host_wdata;
        model_ready = 1'b1;
    end

    task automatic check_field(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual %0h expected %0h", tag, phase, act, exp);
        end
    endtask

    // Compare every output on every clock, away from the active edge
    always @(negedge clk) begin
        if (model_ready && !done) begin
            check_field("R1 slot",        32'(out_slot),        32'(e_slot));
            check_field("R1 step",        32'(out_step),        32'(e_step));
            check_field("R2 word",        out_word,             e_word);
            check_field("R4 keep",        32'(out_keep),        32'(e_keep));
            check_field("R5 frame_start", 32'(out_frame_start), 32'(e_fs));
            check_field("R6 valid",       32'(out_valid),       32'(e_valid));
        end
    end

    task automatic cyc(input logic r, input logic we, input logic [1:0] tgt,
                       input int addr, input logic [WORD_W-1:0] data);
        @(negedge clk);
        run        = r;
        host_we    = we;
        host_tgt   = tgt;
        host_addr  = HADDR_W'(addr);
        host_wdata = data;
    endtask

    task automatic idle_run(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd0, 0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: outputs are zero while held in reset
        check_field("R7 reset valid", 32'(out_valid), 32'd0);
        check_field("R7 reset word",  out_word,       32'd0);
        check_field("R7 reset slot",  32'(out_slot),  32'd0);
        rst = 1'b0;

        phase = "R8 store fill while halted";
        for (int a = 0; a < ALGS; a++) begin
            for (int s = 0; s < STEPS; s++) begin
                cyc(1'b0, 1'b1, 2'd0, a*STEPS + s, 32'hA500_0000 | WORD_W'(a << 8) | WORD_W'(s));
            end
        end

        phase = "R8 tables, R4 links incl. last slot";
        for (int i = 0; i < SLOTS; i++) cyc(1'b0, 1'b1, 2'd1, i, WORD_W'(i % ALGS));
        cyc(1'b0, 1'b1, 2'd2, 2, 32'd1);
        cyc(1'b0, 1'b1, 2'd2, 3, 32'd1);
        cyc(1'b0, 1'b1, 2'd2, SLOTS-1, 32'd1);

        phase = "R1 R2 R4 R5 free run";
        idle_run(3*SLOTS*STEPS);

        phase = "R3 select writes during slots";
        for (int i = 0; i < 2*SLOTS*STEPS; i++) begin
            cyc(1'b1, 1'b1, 2'd1, (i / 3) % SLOTS, WORD_W'((i * 7 + 1) % ALGS));
        end
        idle_run(SLOTS*STEPS);

        phase = "R9 store writes on every cycle";
        for (int i = 0; i < 2*SLOTS*STEPS; i++) begin
            cyc(1'b1, 1'b1, 2'd0, (i * 5) % (ALGS*STEPS), 32'h5A00_0000 + WORD_W'(i));
        end
        idle_run(SLOTS*STEPS);

        phase = "R8 target 3 ignored";
        for (int i = 0; i < SLOTS*STEPS; i++) begin
            cyc(1'b1, 1'b1, 2'd3, i % (ALGS*STEPS), 32'hFFFF_FFFF);
        end
        idle_run(SLOTS*STEPS);

        phase = "R4 link toggles while running";
        for (int i = 0; i < SLOTS*STEPS; i++) begin
            cyc(1'b1, 1'b1, 2'd2, (i / 2) % SLOTS, WORD_W'(i % 3 == 0));
        end
        idle_run(SLOTS*STEPS);

        phase = "R6 halt and resume";
        for (int i = 0; i < 3*SLOTS*STEPS; i++) begin
            cyc((i % 5) < 2 || (i % 7) == 3, 1'b0, 2'd0, 0, '0);
        end
        idle_run(SLOTS*STEPS);

        phase = "R7 reset mid-run clears tables";
        @(negedge clk);
        rst = 1'b1;
        idle_run(2);
        rst = 1'b0;
        idle_run(2*SLOTS*STEPS);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule